// File: doc/BRIEF.md
# Dual Down-Counter Timer with Edge Capture and PWM Toggle

The block holds two 16-bit down-counters, each paired with a 16-bit reload/capture register. A mode field, one of four, sets the role of each counter and of the two pins. In the two timer modes a counter reloads from its paired register when it passes zero. In the two capture modes an edge on an enabled pin saves the counter value and presets the counter to all ones. The pin edge must match the programmed polarity. Pin A drives a square wave by toggling a status bit each time counter 1 passes zero, except in the mode where A serves as a capture input.

Software reaches every register over a single-cycle bus with one address. Writes take effect on the next clock. Reads return data combinationally from the addressed register. A separate clock-select stage outside this block supplies two count-enable strobes. Four interrupt sources, named A to D, each have a sticky pending flag and an enable bit. The interrupt line is high while any enabled flag is set.

The mode is the block's state. It changes only by a software write to the mode control register, and each write is a transition straight to the written mode. There are four states. PWM (code 00) runs counter 1 as a timer that drives the pin and counter 2 as a system timer. DCAP (code 01) uses both pins to capture into counter 1, with counter 2 as a system timer. DUAL (code 10) runs both counters as timers. SCAP (code 11) runs counter 1 as a timer that drives the pin and uses pin B to capture into counter 2.

Top module: `mm_timer`

## Requirements
- R1: Reset clears the mode control register (address 4) and the interrupt control register (address 5). After reset both read 0, `irq` is 0 and `pin_a_oe` is 0. Address 6 always reads 0.
- R2: The mode control register has this layout: bits 1:0 mode (00 PWM, 01 DCAP, 10 DUAL, 11 SCAP), bit 2 A polarity, bit 3 B polarity, bit 4 A enable, bit 5 B enable, bit 6 A output bit. Bit 7 always reads 0.
- R3: A counter decrements on each cycle its count enable is high. Counter 1 (address 0) reloads from register A (address 2) when it is at 0 and enabled. Counter 2 (address 1) reloads from register B (address 3) in the same way. A counter that is a capture target wraps to FFFF instead.
- R4: In PWM, DUAL and SCAP with A enabled, each reload of counter 1 toggles the A output bit. In these three modes, every reload of counter 1 sets pending A. `pin_a_out` shows the A output bit. `pin_a_oe` equals A enable, except in DCAP where it is 0.
- R5: A software write to the mode control register sets the A output bit to `bus_wdata[6]`, even in a cycle where hardware would toggle it.
- R6: In DCAP, a qualified edge on an enabled pin A copies counter 1 into register A, presets counter 1 to FFFF and sets pending A. A qualified edge on an enabled pin B copies counter 1 into register B, presets counter 1 and sets pending B. Both counters are capture targets.
- R7: In SCAP, a qualified edge on an enabled pin B copies counter 2 into register B, presets counter 2 to FFFF and sets pending B; counter 2 is a capture target. In PWM and DUAL, the B enable bit and pin B have no effect.
- R8: A polarity bit of 1 selects rising edges and 0 selects falling edges. An edge of the other direction captures nothing.
- R9: Every wrap or reload of counter 2 sets pending D, in every mode. In DCAP, every wrap of counter 1 sets pending C.
- R10: The interrupt control register has pending flags A..D in bits 3:0 and enables A..D in bits 7:4. Writing a 1 to a pending bit sets it, and writing a 0 leaves it unchanged. Writing a 1 to the matching bit at address 6 clears it. A hardware set in the same cycle wins over that clear.
- R11: `irq` is 1 exactly when some pending flag and its enable are both 1.
- R12: A software write to a counter wins over a preset and over counting in the same cycle. No reload happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_a_in | input | 1 | Pin A input level |
| pin_b_in | input | 1 | Pin B input level |
| pin_a_out | output | 1 | Pin A PWM level |
| pin_a_oe | output | 1 | Pin A output enable |
| cnt1_en | input | 1 | Count strobe for counter 1 |
| cnt2_en | input | 1 | Count strobe for counter 2 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a collision inside one cycle. A software write must meet a hardware update to the same bit or counter: the A output bit written while counter 1 reloads, a counter written while a pin edge presets it, or a clear arriving while a hardware source sets the same flag. To reach each one, the bench first parks a counter at 0 with its count enable low. In one cycle it then raises the enable and issues the competing write, or raises the pin and issues the write. The reference model then gives the winner.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    typedef enum logic [1:0] {
        MODE_PWM  = 2'b00,
        MODE_DCAP = 2'b01,
        MODE_DUAL = 2'b10,
        MODE_SCAP = 2'b11
    } mode_e;

    localparam int ADDR_W     = 3;
    localparam int A_CNT_BASE = 0;
    localparam int A_RC_BASE  = 2;
    localparam int A_MCTL     = 4;
    localparam int A_ICTL     = 5;
    localparam int A_ICLR     = 6;
    localparam int NSRC       = 4;
    localparam int SRC_A      = 0;
    localparam int SRC_B      = 1;
    localparam int SRC_C      = 2;
    localparam int SRC_D      = 3;
endpackage

// File: rtl/mmt_edge.sv
module mmt_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pins;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign edge_o[i] = rise_sel[i] ? (!prev_q[i] && pins[i])
                                       : (prev_q[i] && !pins[i]);
    end
endmodule

// File: rtl/mmt_chan.sv
module mmt_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt,
    input  logic         wr_rc,
    input  logic [W-1:0] wdata,
    input  logic         cnt_en,
    input  logic         preset,
    input  logic         capture,
    input  logic [W-1:0] cap_src,
    input  logic         wrap,
    output logic [W-1:0] cnt,
    output logic [W-1:0] rc,
    output logic         uflow
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    assign uflow = cnt_en && (cnt == '0) && !wr_cnt && !preset;

    always_ff @(posedge clk) begin
        if (wr_cnt)       cnt <= wdata;
        else if (preset)  cnt <= ALL_ONES;
        else if (uflow)   cnt <= wrap ? ALL_ONES : rc;
        else if (cnt_en)  cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_rc)        rc <= wdata;
        else if (capture) rc <= cap_src;
    end

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> cnt == $past(wrap ? ALL_ONES : rc));
    a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !wr_cnt) |=> cnt == ALL_ONES);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !wr_rc) |=> rc == $past(cap_src));
    a_r12_sw_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wdata));
endmodule

// File: rtl/mmt_irq.sv
module mmt_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic         sw_wr,
    input  logic [2*N-1:0] sw_data,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] sw_set, clr;

    assign sw_set = sw_wr  ? sw_data[N-1:0] : '0;
    assign clr    = clr_wr ? clr_mask       : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~clr) | hw_set | sw_set;
            if (sw_wr) en <= sw_data[2*N-1:N];
        end
    end

    assign irq = |(pend & en);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !sw_wr && hw_set == '0) |=> (pend & $past(clr_mask)) == '0);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (pend & $past(pend)) == $past(pend));
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              pin_a_in,
    input  logic              pin_b_in,
    output logic              pin_a_out,
    output logic              pin_a_oe,
    input  logic              cnt1_en,
    input  logic              cnt2_en,
    output logic              irq
);
    localparam int PAD = W - 8;

    mode_e mode_q;
    logic  aedg_q, bedg_q, aen_q, ben_q, aout_q;
    logic  wr_mctl, wr_ictl, wr_iclr;

    assign wr_mctl = bus_wr && (bus_addr == ADDR_W'(A_MCTL));
    assign wr_ictl = bus_wr && (bus_addr == ADDR_W'(A_ICTL));
    assign wr_iclr = bus_wr && (bus_addr == ADDR_W'(A_ICLR));

    // Pin edge detection
    logic [1:0] edges;
    logic       ea, eb;
    mmt_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .pins({pin_b_in, pin_a_in}),
        .rise_sel({bedg_q, aedg_q}),
        .edge_o(edges)
    );
    assign ea = edges[0];
    assign eb = edges[1];

    // Mode decode: roles of counters and pins
    logic         pwm;
    logic [1:0]   preset_v, cap_v, wrap_v, uf_v;
    logic [W-1:0] cnt_v [2];
    logic [W-1:0] rc_v  [2];
    logic [W-1:0] src_v [2];
    logic [NSRC-1:0] hw_set;

    always_comb begin
        pwm      = 1'b0;
        preset_v = '0;
        cap_v    = '0;
        wrap_v   = '0;
        src_v[0] = cnt_v[0];
        src_v[1] = cnt_v[1];
        unique case (mode_q)
            MODE_PWM, MODE_DUAL: begin
                pwm = 1'b1;
            end
            MODE_DCAP: begin
                preset_v[0] = (aen_q && ea) || (ben_q && eb);
                cap_v[0]    = aen_q && ea;
                cap_v[1]    = ben_q && eb;
                src_v[1]    = cnt_v[0];
                wrap_v      = 2'b11;
            end
            MODE_SCAP: begin
                pwm         = 1'b1;
                preset_v[1] = ben_q && eb;
                cap_v[1]    = ben_q && eb;
                wrap_v[1]   = 1'b1;
            end
        endcase
    end

    for (genvar i = 0; i < 2; i++) begin : g_chan
        logic en_i;
        assign en_i = (i == 0) ? cnt1_en : cnt2_en;
        mmt_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_cnt(bus_wr && (bus_addr == ADDR_W'(A_CNT_BASE + i))),
            .wr_rc(bus_wr && (bus_addr == ADDR_W'(A_RC_BASE + i))),
            .wdata(bus_wdata),
            .cnt_en(en_i),
            .preset(preset_v[i]),
            .capture(cap_v[i]),
            .cap_src(src_v[i]),
            .wrap(wrap_v[i]),
            .cnt(cnt_v[i]),
            .rc(rc_v[i]),
            .uflow(uf_v[i])
        );
    end

    always_comb begin
        hw_set        = '0;
        hw_set[SRC_A] = pwm ? uf_v[0] : cap_v[0];
        hw_set[SRC_B] = cap_v[1];
        hw_set[SRC_C] = (mode_q == MODE_DCAP) && uf_v[0];
        hw_set[SRC_D] = uf_v[1];
    end

    // Mode control register (state register)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PWM;
            {aedg_q, bedg_q, aen_q, ben_q, aout_q} <= '0;
        end else if (wr_mctl) begin
            mode_q <= mode_e'(bus_wdata[1:0]);
            aedg_q <= bus_wdata[2];
            bedg_q <= bus_wdata[3];
            aen_q  <= bus_wdata[4];
            ben_q  <= bus_wdata[5];
            aout_q <= bus_wdata[6];
        end else if (pwm && aen_q && uf_v[0]) begin
            aout_q <= !aout_q;
        end
    end

    logic [NSRC-1:0] pend, ien;
    mmt_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .hw_set(hw_set),
        .sw_wr(wr_ictl),
        .sw_data(bus_wdata[2*NSRC-1:0]),
        .clr_wr(wr_iclr),
        .clr_mask(bus_wdata[NSRC-1:0]),
        .pend(pend),
        .en(ien),
        .irq(irq)
    );

    // Outputs
    assign pin_a_out = aout_q;
    assign pin_a_oe  = aen_q && (mode_q != MODE_DCAP);

    always_comb begin
        unique case (bus_addr)
            3'd0:    bus_rdata = cnt_v[0];
            3'd1:    bus_rdata = cnt_v[1];
            3'd2:    bus_rdata = rc_v[0];
            3'd3:    bus_rdata = rc_v[1];
            3'd4:    bus_rdata = {{PAD{1'b0}}, 1'b0, aout_q, ben_q, aen_q,
                                  bedg_q, aedg_q, mode_q};
            3'd5:    bus_rdata = {{PAD{1'b0}}, ien, pend};
            default: bus_rdata = '0;
        endcase
    end

    a_r5_sw_aout: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mctl |=> aout_q == $past(bus_wdata[6]));
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && aen_q && uf_v[0] && !wr_mctl) |=> aout_q != $past(aout_q));
endmodule

// File: tb/sim_mm_timer.sv
`timescale 1ns/1ps
module sim_mm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pin_a_in = 1'b0, pin_b_in = 1'b0;
    logic        pin_a_out, pin_a_oe;
    logic        cnt1_en = 1'b0, cnt2_en = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mm_timer u0 (.*);

    // Behavioural reference model
    logic [15:0] mc1 = 0, mc2 = 0, mra = 0, mrb = 0;
    logic [1:0]  mmode = 0;
    logic        maedg = 0, mbedg = 0, maen = 0, mben = 0, maout = 0;
    logic [3:0]  mpend = 0, men = 0;
    logic        mpa = 0, mpb = 0;

    always @(posedge clk) begin : model
        logic ea, eb, pre1, pre2, ca, cb1, cb2, u1, u2, w, pwm;
        logic [2:0] a;
        logic [15:0] o1, o2;
        logic [3:0] hw, sw, clr;
        if (!rst_n) begin
            mmode = 0; maedg = 0; mbedg = 0; maen = 0; mben = 0; maout = 0;
            mpend = 0; men = 0; mpa = 0; mpb = 0;
        end else begin
            ea = maedg ? (!mpa && pin_a_in) : (mpa && !pin_a_in);
            eb = mbedg ? (!mpb && pin_b_in) : (mpb && !pin_b_in);
            o1 = mc1; o2 = mc2; w = bus_wr; a = bus_addr;
            pwm  = (mmode != 2'd1);
            pre1 = (mmode == 2'd1) && ((maen && ea) || (mben && eb));
            pre2 = (mmode == 2'd3) && mben && eb;
            ca   = (mmode == 2'd1) && maen && ea;
            cb1  = (mmode == 2'd1) && mben && eb;
            cb2  = pre2;
            u1 = cnt1_en && o1 == 0 && !(w && a == 0) && !pre1;
            u2 = cnt2_en && o2 == 0 && !(w && a == 1) && !pre2;
            if (w && a == 0) mc1 = bus_wdata;
            else if (pre1) mc1 = 16'hFFFF;
            else if (cnt1_en) mc1 = (o1 == 0) ? ((mmode == 2'd1) ? 16'hFFFF : mra) : o1 - 1;
            if (w && a == 1) mc2 = bus_wdata;
            else if (pre2) mc2 = 16'hFFFF;
            else if (cnt2_en) mc2 = (o2 == 0) ? ((mmode[0]) ? 16'hFFFF : mrb) : o2 - 1;
            hw = '0;
            hw[0] = pwm ? u1 : ca;
            hw[1] = cb1 || cb2;
            hw[2] = (mmode == 2'd1) && u1;
            hw[3] = u2;
            if (w && a == 2) mra = bus_wdata; else if (ca) mra = o1;
            if (w && a == 3) mrb = bus_wdata;
            else if (cb1) mrb = o1;
            else if (cb2) mrb = o2;
            if (w && a == 4) begin
                mmode = bus_wdata[1:0]; maedg = bus_wdata[2]; mbedg = bus_wdata[3];
                maen = bus_wdata[4]; mben = bus_wdata[5]; maout = bus_wdata[6];
            end else if (pwm && maen && u1) maout = !maout;
            sw  = (w && a == 5) ? bus_wdata[3:0] : 4'h0;
            clr = (w && a == 6) ? bus_wdata[3:0] : 4'h0;
            mpend = (mpend & ~clr) | hw | sw;
            if (w && a == 5) men = bus_wdata[7:4];
            mpa = pin_a_in; mpb = pin_b_in;
        end
    end

    function automatic logic [15:0] mread(input logic [2:0] ad);
        case (ad)
            3'd0: return mc1;
            3'd1: return mc2;
            3'd2: return mra;
            3'd3: return mrb;
            3'd4: return {9'd0, maout, mben, maen, mbedg, maedg, mmode};
            3'd5: return {8'd0, men, mpend};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R11 irq", {15'd0, irq}, {15'd0, |(mpend & men)});
            check("R4 pin_a_out", {15'd0, pin_a_out}, {15'd0, maout});
            check("R4 pin_a_oe", {15'd0, pin_a_oe}, {15'd0, maen && mmode != 2'd1});
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] ad, input logic [15:0] d);
        bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ad, input string req);
        bus_addr = ad;
        #0.5;
        check(req, bus_rdata, mread(ad));
    endtask

    task automatic summary;
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1: reset state
        rd(4, "R1 mctl"); check("R1 mctl zero", bus_rdata, 16'h0);
        rd(5, "R1 ictl"); check("R1 ictl zero", bus_rdata, 16'h0);
        rd(6, "R1 iclr reads 0");
        check("R1 irq", {15'd0, irq}, 16'h0);
        check("R1 oe", {15'd0, pin_a_oe}, 16'h0);
        // R2: layout, reserved bit
        wr(4, 16'h00FF);
        rd(4, "R2 layout"); check("R2 bit7 reads 0", bus_rdata, 16'h007F);
        wr(4, 16'h0000);
        // R3/R4: DUAL mode, A enabled, reloads and toggles
        wr(2, 16'd3); wr(3, 16'd5); wr(0, 16'd2); wr(1, 16'd1);
        wr(5, 16'h00F0);
        wr(4, 16'h0012);
        cnt1_en = 1; cnt2_en = 1;
        for (int i = 0; i < 14; i++) begin
            tick();
            rd(0, "R3 cnt1"); rd(1, "R3 cnt2"); rd(5, "R4 R9 pend");
        end
        cnt1_en = 0; cnt2_en = 0;
        // R10: clear, sw set, write of 0 does not clear
        wr(6, 16'h000F); rd(5, "R10 clear");
        wr(5, 16'h00F5); rd(5, "R10 sw set");
        wr(5, 16'h00F0); rd(5, "R10 zero no clear");
        wr(6, 16'h0001); rd(5, "R10 clear A");
        // R10: hw set wins over clear of D
        wr(1, 16'h0000); wr(6, 16'h000F);
        cnt2_en = 1; wr(6, 16'h0008); cnt2_en = 0;
        rd(5, "R10 hw wins clear"); check("R10 D still set", bus_rdata & 16'h8, 16'h8);
        wr(6, 16'h000F); wr(5, 16'h0010); rd(5, "R11 enable only A");
        // R5: sw write of A output collides with reload toggle
        wr(0, 16'h0000); rd(4, "R5 pre");
        cnt1_en = 1; wr(4, {9'd0, maout, 6'h12}); cnt1_en = 0;
        rd(4, "R5 sw wins"); rd(0, "R5 cnt1 reloaded");
        // R6/R8: DCAP, A rising, B falling
        wr(4, 16'h0035); wr(0, 16'd100); wr(1, 16'd50);
        cnt1_en = 1; tick(3);
        pin_a_in = 1; tick(); rd(2, "R6 capA"); rd(0, "R6 preset"); rd(5, "R6 pendA");
        tick(2); pin_a_in = 0; tick(); rd(2, "R8 falling A ignored"); rd(0, "R8 cnt1");
        pin_b_in = 1; tick(); rd(3, "R8 rising B ignored");
        tick(2); pin_b_in = 0; tick(); rd(3, "R6 capB"); rd(0, "R6 presetB"); rd(5, "R6 pendB");
        cnt1_en = 0;
        // R9: wrap of counter 1 in DCAP sets C
        wr(0, 16'h0000); cnt1_en = 1; tick(); cnt1_en = 0;
        rd(0, "R9 wrap FFFF"); rd(5, "R9 pend C");
        // R12: sw counter write collides with preset
        pin_a_in = 1; wr(0, 16'h1234); rd(0, "R12 sw wins"); rd(2, "R12 capA");
        pin_a_in = 0; tick();
        // R7: SCAP, B rising presets counter 2
        wr(4, 16'h003B); wr(1, 16'd40); cnt2_en = 1; tick(2);
        pin_b_in = 1; tick(); rd(1, "R7 preset cnt2"); rd(3, "R7 capB"); rd(5, "R7 pendB");
        pin_b_in = 0; tick();
        wr(1, 16'h0000); tick(); rd(1, "R9 cnt2 wraps in SCAP"); cnt2_en = 0;
        // R7: B has no effect in PWM
        wr(4, 16'h0038); wr(1, 16'd7); wr(3, 16'd9); tick();
        pin_b_in = 1; tick(); rd(1, "R7 pwm cnt2 kept"); rd(3, "R7 pwm rcB kept");
        pin_b_in = 0; tick();
        // R4: PWM mode toggles from counter 1
        wr(2, 16'd1); wr(0, 16'd0); cnt1_en = 1;
        for (int i = 0; i < 6; i++) begin tick(); rd(4, "R4 aout"); end
        cnt1_en = 0;
        wr(5, 16'h00F0); tick(); rd(5, "R11 final");
        tick(2);
        summary();
    end
endmodule